// File: doc/BRIEF.md
# Row-Sequenced Parallel Scan Controller

This block drives the clocking of a scan architecture in which every row of flip-flops is written in one step from a parallel data bus, so nothing is shifted serially. When test mode is requested it takes the circuit off its functional clock. It then visits the rows in ascending order, one row per test-clock period. For the visited row it raises that row's enable and gives it a single gated clock pulse. After the last row it spends one capture cycle in which every row clock fires and no row enable is high. It repeats this round for each pattern until test mode is withdrawn.

The row enable of the visited row changes on the falling edge of the test clock and stays high for one full period. The row's clock is the high phase of the test clock that follows, so each clock edge comes half a period after its enable. A round therefore takes NUM_ROWS + 1 cycles. Status outputs give the row being loaded, a flag for the loading cycles (so the tester can present primary inputs), a capture flag and an end-of-round strobe.

Top module: `scan_rowseq_ctrl`

## Requirements
- R1: While the synchronous active-high reset is applied, all row enables, all row clocks, the bypass select and all status outputs are low.
- R2: From idle, a test-enable that is high at a rising test-clock edge sets the bypass select right after that edge. Row 0's enable rises at the next falling edge.
- R3: While loading, the rows are enabled in ascending index order, one per test-clock period, and each row once per round.
- R4: A row enable rises and falls on falling test-clock edges and holds through the whole period, including the following high phase. A row clock is low whenever the test clock is low, and follows the test clock high during its row's enable window.
- R5: At no time is more than one row enable high, and during loading no row clock other than the enabled row's pulses.
- R6: The period after row NUM_ROWS-1 is a capture cycle: all row enables are low, every row clock pulses once, and the capture flag (bit value 1) is high for exactly that period.
- R7: The end-of-round strobe is high during the capture cycle and low in every other period.
- R8: The load-active flag is high during exactly the NUM_ROWS loading periods. The row index output equals the enabled row during those periods and is 0 otherwise.
- R9: If test-enable is still high at the end of capture, the next round starts with row 0 in the very next period, with no idle gap.
- R10: Lowering test-enable during a round has no effect until the round completes its capture cycle. The block then returns to idle and clears the bypass select.
- R11: Reset applied in the middle of a round aborts it. The bypass clears right after the next rising edge, enables and clocks go low, and a later start begins again at row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_i | input | 1 | Synchronous reset, active high |
| test_en_i | input | 1 | Request for test-mode sequencing |
| row_en_o | output | NUM_ROWS | Per-row scan enable |
| row_clk_o | output | NUM_ROWS | Per-row gated scan clock |
| func_bypass_o | output | 1 | High: circuit clocked by the test controller instead of the functional clock |
| capture_o | output | 1 | Capture cycle in progress |
| round_end_o | output | 1 | End-of-round strobe |
| load_active_o | output | 1 | A row is being loaded this period |
| row_idx_o | output | $clog2(NUM_ROWS) | Index of the row being loaded |

## Verification
The bench samples every period twice, once in the low phase and once in the high phase. This catches an enable that switches on the wrong edge, and a row clock that glitches in the low phase or pulses in the wrong half. Back-to-back rounds expose a controller that inserts an idle period after capture or restarts from the wrong row. A test-enable dropped mid-round must not cut the round short, since that would skip rows and lose the capture. A reset in mid-round must clear the sequence, and the restart must begin at row 0 and not resume at the stale row.

// File: rtl/scan_rowseq_pkg.sv
package scan_rowseq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_CAPT = 2'd2
    } seq_phase_e;

    typedef struct packed {
        logic load;
        logic capture;
        logic round_end;
    } seq_flags_t;

    localparam seq_flags_t FLAGS_NONE = '{load: 1'b0, capture: 1'b0, round_end: 1'b0};

    // Phase transition; leaving a round is only possible from capture.
    function automatic seq_phase_e next_phase(seq_phase_e cur, logic last_row, logic test_en);
        seq_phase_e nxt;
        case (cur)
            SEQ_IDLE: nxt = test_en ? SEQ_LOAD : SEQ_IDLE;
            SEQ_LOAD: nxt = last_row ? SEQ_CAPT : SEQ_LOAD;
            SEQ_CAPT: nxt = test_en ? SEQ_LOAD : SEQ_IDLE;
            default:  nxt = SEQ_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic seq_flags_t phase_flags(seq_phase_e cur);
        seq_flags_t f;
        f = FLAGS_NONE;
        f.load      = (cur == SEQ_LOAD);
        f.capture   = (cur == SEQ_CAPT);
        f.round_end = (cur == SEQ_CAPT);
        return f;
    endfunction

endpackage

// File: rtl/rowseq_counter.sv
module rowseq_counter
    import scan_rowseq_pkg::*;
#(
    parameter int NUM_ROWS = 4,
    localparam int IDX_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             test_en_i,
    output seq_phase_e       phase_o,
    output logic [IDX_W-1:0] row_o
);

    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(NUM_ROWS - 1);

    seq_phase_e       phase_q;
    logic [IDX_W-1:0] row_q;
    logic             last_row;

    assign last_row = (row_q == LAST_ROW);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= SEQ_IDLE;
            row_q   <= '0;
        end else begin
            phase_q <= next_phase(phase_q, last_row, test_en_i);
            if (phase_q == SEQ_LOAD && !last_row) begin
                row_q <= row_q + 1'b1;
            end else begin
                row_q <= '0;
            end
        end
    end

    assign phase_o = phase_q;
    assign row_o   = row_q;

endmodule

// File: rtl/rowseq_decode.sv
module rowseq_decode
    import scan_rowseq_pkg::*;
#(
    parameter int NUM_ROWS = 4,
    localparam int IDX_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  seq_phase_e        phase_i,
    input  logic [IDX_W-1:0]  row_i,
    output logic [NUM_ROWS-1:0] en_next_o,
    output logic [NUM_ROWS-1:0] gate_next_o,
    output seq_flags_t        flags_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic loading;
    logic capturing;

    assign loading   = (phase_i == SEQ_LOAD);
    assign capturing = (phase_i == SEQ_CAPT);

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        assign en_next_o[r]   = loading && (row_i == IDX_W'(r));
        assign gate_next_o[r] = en_next_o[r] || capturing;
    end

    assign flags_o = phase_flags(phase_i);
    assign idx_o   = loading ? row_i : '0;

endmodule

// File: rtl/rowseq_gate.sv
module rowseq_gate #(
    parameter int NUM_ROWS = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_ROWS-1:0] en_next_i,
    input  logic [NUM_ROWS-1:0] gate_next_i,
    output logic [NUM_ROWS-1:0] row_en_o,
    output logic [NUM_ROWS-1:0] row_clk_o
);

    logic [NUM_ROWS-1:0] en_q;
    logic [NUM_ROWS-1:0] gate_q;

    // Registered while the test clock is low, so the AND below cannot glitch.
    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            en_q   <= '0;
            gate_q <= '0;
        end else begin
            en_q   <= en_next_i;
            gate_q <= gate_next_i;
        end
    end

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_gate
        assign row_clk_o[r] = gate_q[r] & clk_i;
    end

    assign row_en_o = en_q;

endmodule

// File: rtl/scan_rowseq_ctrl.sv
module scan_rowseq_ctrl
    import scan_rowseq_pkg::*;
#(
    parameter int NUM_ROWS = 4,
    localparam int IDX_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                test_en_i,
    output logic [NUM_ROWS-1:0] row_en_o,
    output logic [NUM_ROWS-1:0] row_clk_o,
    output logic                func_bypass_o,
    output logic                capture_o,
    output logic                round_end_o,
    output logic                load_active_o,
    output logic [IDX_W-1:0]    row_idx_o
);

    seq_phase_e          phase;
    logic [IDX_W-1:0]    row;
    logic [NUM_ROWS-1:0] en_next;
    logic [NUM_ROWS-1:0] gate_next;
    seq_flags_t          flags_next;
    seq_flags_t          flags_q;
    logic [IDX_W-1:0]    idx_next;
    logic [IDX_W-1:0]    idx_q;

    rowseq_counter #(.NUM_ROWS(NUM_ROWS)) counter_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .test_en_i (test_en_i),
        .phase_o   (phase),
        .row_o     (row)
    );

    rowseq_decode #(.NUM_ROWS(NUM_ROWS)) decode_i (
        .phase_i     (phase),
        .row_i       (row),
        .en_next_o   (en_next),
        .gate_next_o (gate_next),
        .flags_o     (flags_next),
        .idx_o       (idx_next)
    );

    rowseq_gate #(.NUM_ROWS(NUM_ROWS)) gate_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .en_next_i   (en_next),
        .gate_next_i (gate_next),
        .row_en_o    (row_en_o),
        .row_clk_o   (row_clk_o)
    );

    // Status aligned with the enables: updated on the falling edge.
    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            flags_q <= FLAGS_NONE;
            idx_q   <= '0;
        end else begin
            flags_q <= flags_next;
            idx_q   <= idx_next;
        end
    end

    assign func_bypass_o = (phase != SEQ_IDLE);
    assign capture_o     = flags_q.capture;
    assign round_end_o   = flags_q.round_end;
    assign load_active_o = flags_q.load;
    assign row_idx_o     = idx_q;

endmodule

// File: rtl/scan_rowseq_chk.sv
module scan_rowseq_chk #(
    parameter int NUM_ROWS = 4,
    localparam int IDX_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic [NUM_ROWS-1:0] row_en_o,
    input logic                capture_o,
    input logic                load_active_o,
    input logic [IDX_W-1:0]    row_idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROWS - 1);

    // R5
    one_row_enabled_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        $onehot0(row_en_o));

    // R8
    load_has_row_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        load_active_o |-> ($countones(row_en_o) == 1));

    // R3
    row_ascends_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        (load_active_o && row_idx_o != LAST_IDX) |=>
            (load_active_o && row_idx_o == $past(row_idx_o) + 1'b1));

    // R6
    last_row_to_capture_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        (load_active_o && row_idx_o == LAST_IDX) |=> (capture_o && row_en_o == '0));

    // R6
    single_capture_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        capture_o |=> !capture_o);

endmodule

bind scan_rowseq_ctrl scan_rowseq_chk #(.NUM_ROWS(NUM_ROWS)) chk_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .row_en_o      (row_en_o),
    .capture_o     (capture_o),
    .load_active_o (load_active_o),
    .row_idx_o     (row_idx_o)
);

// File: tb/scan_rowseq_ctrl_tb_top.sv
`timescale 1ns/1ps
module scan_rowseq_ctrl_tb_top;

    localparam int ROWS = 4;
    localparam int NVEC = 19;

    typedef struct packed {
        logic       te;
        logic       byp;
        logic [3:0] en;
        logic [3:0] ck;
        logic       cap;
        logic       rend;
        logic       load;
        logic [1:0] idx;
    } vec_t;

    // te, bypass, enables, clocks in high phase, capture, round end, load, index
    localparam vec_t VEC [NVEC] = '{
        {1'b1, 1'b1, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b1, 2'd0},
        {1'b1, 1'b1, 4'b0010, 4'b0010, 1'b0, 1'b0, 1'b1, 2'd1},
        {1'b1, 1'b1, 4'b0100, 4'b0100, 1'b0, 1'b0, 1'b1, 2'd2},
        {1'b1, 1'b1, 4'b1000, 4'b1000, 1'b0, 1'b0, 1'b1, 2'd3},
        {1'b1, 1'b1, 4'b0000, 4'b1111, 1'b1, 1'b1, 1'b0, 2'd0},
        {1'b1, 1'b1, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b1, 2'd0},
        {1'b1, 1'b1, 4'b0010, 4'b0010, 1'b0, 1'b0, 1'b1, 2'd1},
        {1'b1, 1'b1, 4'b0100, 4'b0100, 1'b0, 1'b0, 1'b1, 2'd2},
        {1'b1, 1'b1, 4'b1000, 4'b1000, 1'b0, 1'b0, 1'b1, 2'd3},
        {1'b0, 1'b1, 4'b0000, 4'b1111, 1'b1, 1'b1, 1'b0, 2'd0},
        {1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b1, 1'b1, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b1, 2'd0},
        {1'b0, 1'b1, 4'b0010, 4'b0010, 1'b0, 1'b0, 1'b1, 2'd1},
        {1'b0, 1'b1, 4'b0100, 4'b0100, 1'b0, 1'b0, 1'b1, 2'd2},
        {1'b0, 1'b1, 4'b1000, 4'b1000, 1'b0, 1'b0, 1'b1, 2'd3},
        {1'b0, 1'b1, 4'b0000, 4'b1111, 1'b1, 1'b1, 1'b0, 2'd0},
        {1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b1, 1'b1, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b1, 2'd0},
        {1'b1, 1'b1, 4'b0010, 4'b0010, 1'b0, 1'b0, 1'b1, 2'd1}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            test_en = 1'b0;
    logic [ROWS-1:0] row_en;
    logic [ROWS-1:0] row_clk;
    logic            bypass;
    logic            capture;
    logic            round_end;
    logic            load_active;
    logic [1:0]      row_idx;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    scan_rowseq_ctrl #(.NUM_ROWS(ROWS)) dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .test_en_i     (test_en),
        .row_en_o      (row_en),
        .row_clk_o     (row_clk),
        .func_bypass_o (bypass),
        .capture_o     (capture),
        .round_end_o   (round_end),
        .load_active_o (load_active),
        .row_idx_o     (row_idx)
    );

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string tag(int i, string dflt);
        if (i == 5) return "R9";
        if (i == 10 || (i >= 12 && i <= 16)) return "R10";
        return dflt;
    endfunction

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        vec_t prev;
        prev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1: reset state, low phase
        chk("R1", "row_en", 8'(row_en), 8'h0);
        chk("R1", "row_clk", 8'(row_clk), 8'h0);
        chk("R1", "bypass", 8'(bypass), 8'h0);
        chk("R1", "flags", {5'b0, capture, round_end, load_active}, 8'h0);
        @(posedge clk); #1;
        chk("R1", "row_clk high phase", 8'(row_clk), 8'h0);
        @(negedge clk); #1;
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VEC[i];
            test_en = v.te;
            @(posedge clk); #1;
            chk(tag(i, "R2"), "bypass", 8'(bypass), 8'(v.byp));
            chk(tag(i, "R4"), "row_clk high", 8'(row_clk), 8'(prev.ck));
            chk("R4", "row_en held in high phase", 8'(row_en), 8'(prev.en));
            @(negedge clk); #1;
            chk(tag(i, "R3"), "row_en", 8'(row_en), 8'(v.en));
            chk("R5", "enable count", 8'($countones(row_en)), 8'($countones(v.en)));
            chk("R4", "row_clk low", 8'(row_clk), 8'h0);
            chk(tag(i, "R6"), "capture", 8'(capture), 8'(v.cap));
            chk("R7", "round_end", 8'(round_end), 8'(v.rend));
            chk("R8", "load_active", 8'(load_active), 8'(v.load));
            chk("R8", "row_idx", 8'(row_idx), 8'(v.idx));
            prev = v;
        end
        @(posedge clk); #1;
        chk("R4", "row_clk high last", 8'(row_clk), 8'(prev.ck));

        // R11: reset in mid-round (row 2 loading now)
        @(negedge clk); #1;
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R11", "bypass after reset", 8'(bypass), 8'h0);
        @(negedge clk); #1;
        chk("R11", "row_en after reset", 8'(row_en), 8'h0);
        chk("R11", "load after reset", 8'(load_active), 8'h0);
        @(posedge clk); #1;
        chk("R11", "row_clk after reset", 8'(row_clk), 8'h0);
        @(negedge clk); #1;
        rst = 1'b0;
        test_en = 1'b1;
        @(posedge clk); #1;
        chk("R11", "bypass restart", 8'(bypass), 8'h1);
        @(negedge clk); #1;
        chk("R11", "restart at row 0", 8'(row_en), 8'h1);
        chk("R11", "restart idx", 8'(row_idx), 8'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule